// File: doc/BRIEF.md
# Clause-22 Management Bus Controller

This block is a host-programmable master for the two-wire PHY management bus of IEEE 802.3 clause 22. It derives the management clock from the system clock through an even divider. It builds the serial frame for a single register write or a single register read, and it can also repeat one read without pause to track the link state of a PHY. The pad is left to the integrating level: the block drives a data value and an output enable and receives the sampled line on a separate input.

The host uses a small word-addressed register file with these offsets:
- 0: mode
- 1: command
- 2: target address
- 3: write data
- 4: read data, read-only
- 5: status, read-only

To run an operation, the host loads the target and the data, writes the command, and polls the busy flag until it clears. It then collects the read data and writes zero to the command register. While scanning, the status register reports a link-fail flag taken from each result, and a not-yet-valid flag that stays set until the first scan result arrives.

Top module: `mdio_ctrl`

## Requirements
- R1: After reset, every readable register returns zero, `mdc` is low and `mdio_oe` is low.
- R2: Mode bits 7:1 set half the divider, so one `mdc` period is the even value mode[7:0] in system clocks. That period is high for half of it and low for half of it. Bit 0 always reads as zero. A divider of 0 behaves as 2.
- R3: A write frame has four parts, sent MSB first and driven throughout:
  - 32 ones of preamble;
  - start 01, then opcode 01;
  - PHY address (address register bits 4:0), then register address (bits 12:8);
  - turnaround 10, then the 16 write-data bits.
  `mdio_out`/`mdio_oe` change only while `mdc` is low.
- R4: A read frame uses opcode 10. The block releases `mdio_oe` for the two turnaround bits and the 16 data bits. It samples `mdio_in` on each rising `mdc` edge of the data bits and places the 16-bit result in the read-data register (offset 4) when the frame ends.
- R5: With mode bit 8 set, frames start directly with the start bits and carry no preamble.
- R6: Status bit 1 (busy) reads 1 from the cycle after a command write that starts an operation until that operation ends. At all other idle times it reads 0, and `mdc` stays low while idle.
- R7: A command written while busy does not launch a frame. Write data changed during a frame does not alter that frame.
- R8: Command bit 0 starts a scan of repeated reads, which continues until the bit is cleared; the frame in progress then completes. Status bit 2 (invalid) is set when the scan starts and clears when the first scan read completes. Status bit 0 (link fail) takes the inverse of bit 2 of every scan result.
- R9: Command bit 2 requests a write and bit 1 requests a read. When both are written together, the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data driven by the block |
| mdio_oe | output | 1 | Output enable for `mdio_out` |
| mdio_in | input | 1 | Management data sampled from the line |

## Verification
The hardest situation to reach is a scan whose link-fail flag must change value between two back-to-back frames. Two more states are hard to reach: the window just after a scan starts, when the invalid flag is set, and a command that lands in the middle of a busy frame. The bench uses a PHY model that answers reads from its own register array. It changes that array while the scan runs and waits on its count of decoded frames before it reads status. To hit the busy window, it issues a second command and changes the write data straight after the first command, then checks that exactly one frame with the original data came out.

// File: rtl/mdio_ctrl.sv
module mdio_ctrl #(
  parameter int PRE_BITS = 32,
  parameter int CNT_W    = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int FRAME_BITS = 32;
  localparam int BIT_W      = $clog2(PRE_BITS + FRAME_BITS + 1);
  localparam logic [2:0] A_MODE = 3'd0, A_CMD = 3'd1, A_ADDR = 3'd2,
                         A_TXD  = 3'd3, A_RXD = 3'd4, A_STAT = 3'd5;

  logic [8:0]       mode_q;
  logic [2:0]       cmd_q;
  logic [4:0]       phy_q, rga_q;
  logic [15:0]      tx_q, rx_q, sh_q;
  logic             link_fail, invalid, pend, pend_wr;
  logic             active, op_wr, op_scan, op_nopre;
  logic [31:0]      frame_q;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitcnt;

  wire [CNT_W-1:0] half    = (mode_q[CNT_W:1] == '0) ? CNT_W'(1) : mode_q[CNT_W:1];
  wire [BIT_W-1:0] pre_len = op_nopre ? '0 : BIT_W'(PRE_BITS);
  wire [BIT_W-1:0] last    = pre_len + BIT_W'(FRAME_BITS - 1);
  wire [BIT_W-1:0] j       = bitcnt - pre_len;
  wire             in_pre  = bitcnt < pre_len;
  wire             busy    = active | pend | cmd_q[0];
  wire             tick    = cnt == half - CNT_W'(1);
  wire             start   = !active && (pend || cmd_q[0]);
  wire             wr_sel  = pend & pend_wr;
  wire             cmd_wr  = reg_wr && reg_addr == A_CMD;

  assign mdio_out = !active ? 1'b1 : (in_pre ? 1'b1 : frame_q[~j[4:0]]);
  assign mdio_oe  = active && (in_pre || op_wr || j < BIT_W'(14));

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = {7'd0, mode_q};
      A_CMD:   reg_rdata = {13'd0, cmd_q};
      A_ADDR:  reg_rdata = {3'd0, rga_q, 3'd0, phy_q};
      A_TXD:   reg_rdata = tx_q;
      A_RXD:   reg_rdata = rx_q;
      A_STAT:  reg_rdata = {13'd0, invalid, busy, link_fail};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; cmd_q <= '0; phy_q <= '0; rga_q <= '0; tx_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_MODE: mode_q <= {reg_wdata[8:1], 1'b0};
        A_CMD:  cmd_q  <= reg_wdata[2:0];
        A_ADDR: begin phy_q <= reg_wdata[4:0]; rga_q <= reg_wdata[12:8]; end
        A_TXD:  tx_q   <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; pend_wr <= 1'b0; active <= 1'b0; op_wr <= 1'b0;
      op_scan <= 1'b0; op_nopre <= 1'b0; frame_q <= '0; cnt <= '0;
      bitcnt <= '0; mdc <= 1'b0; sh_q <= '0; rx_q <= '0;
      link_fail <= 1'b0; invalid <= 1'b0;
    end else begin
      if (cmd_wr && !busy && (reg_wdata[1] || reg_wdata[2])) begin
        pend    <= 1'b1;
        pend_wr <= reg_wdata[2];
      end
      if (cmd_wr && reg_wdata[0] && !cmd_q[0]) invalid <= 1'b1;
      if (start) begin
        active   <= 1'b1;
        pend     <= 1'b0;
        op_wr    <= wr_sel;
        op_scan  <= !pend;
        op_nopre <= mode_q[8];
        frame_q  <= {2'b01, wr_sel ? 2'b01 : 2'b10, phy_q, rga_q,
                     wr_sel ? {2'b10, tx_q} : 18'h0};
        bitcnt   <= '0;
        cnt      <= '0;
        mdc      <= 1'b0;
      end else if (active) begin
        if (tick) begin
          cnt <= '0;
          mdc <= ~mdc;
          if (mdc) begin
            if (bitcnt == last) begin
              active <= 1'b0;
              if (!op_wr) rx_q <= sh_q;
              if (op_scan) begin
                link_fail <= ~sh_q[2];
                invalid   <= 1'b0;
              end
            end else begin
              bitcnt <= bitcnt + BIT_W'(1);
            end
          end else if (!op_wr && !in_pre && j >= BIT_W'(16)) begin
            sh_q <= {sh_q[14:0], mdio_in};
          end
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  // R6
  busy_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && (reg_wdata[1] || reg_wdata[2])) |=> busy);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R3
  stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> $stable({mdio_out, mdio_oe}));

  // R2
  mdc_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$stable(mdc)) |-> ($past(cnt) == $past(half) - CNT_W'(1)));

  // R8
  lf_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(link_fail) |-> ($past(active) && !active && $past(op_scan)));
endmodule

// File: tb/tb_mdio_ctrl.sv
module tb_mdio_ctrl;
  logic clk = 0, rst_n = 0, reg_wr = 0, mdio_in = 1;
  logic [2:0]  reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic mdc, mdio_out, mdio_oe;

  mdio_ctrl dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
                 .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
                 .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in));

  always #4 clk = ~clk;

  typedef struct packed {
    logic       wr;
    logic [4:0] phy;
    logic [4:0] rg;
    logic [15:0] d;
    logic [5:0] pre;
  } exp_t;

  exp_t q[$];
  int checks = 0, failures = 0, frames = 0, cyc = 0, exp_pre = 32;
  bit done = 0, scan_on = 0;
  logic [4:0] scan_phy, scan_reg;
  logic [15:0] phy_mem [32];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // PHY model and monitor
  int st = 0, ones = 0, n = 0;
  logic [11:0] hdr;
  logic [1:0]  ta;
  logic [15:0] dsh, rdval;
  bit oe_bad;

  always @(posedge mdc) begin
    case (st)
      0: if (mdio_oe) begin
           if (mdio_out) ones++;
           else st = 1;
         end
      1: begin
           if (mdio_out !== 1'b1) begin checks++; failures++;
             $display("FAIL R3 start bit actual=%0b expected=1", mdio_out); end
           n = 0; hdr = '0; st = 2;
         end
      2: begin
           hdr = {hdr[10:0], mdio_out}; n++;
           if (n == 12) begin
             st = 3; n = 0; oe_bad = 0; ta = '0; dsh = '0;
             rdval = phy_mem[hdr[4:0]];
           end
         end
      default: begin
           n++;
           if (hdr[11:10] == 2'b10) begin
             if (mdio_oe) oe_bad = 1;
           end else if (n <= 2) ta = {ta[0], mdio_out};
           else dsh = {dsh[14:0], mdio_out};
           if (n == 18) begin
             exp_t e;
             logic is_wr;
             is_wr = (hdr[11:10] == 2'b01);
             frames++;
             if (is_wr) begin
               chk("R3 turnaround", ta, 2'b10);
               phy_mem[hdr[4:0]] = dsh;
             end else begin
               chk("R4 opcode", hdr[11:10], 2'b10);
               chk("R4 release", oe_bad, 0);
             end
             if (q.size() > 0) begin
               e = q.pop_front();
               chk("R3/R9 op", is_wr, e.wr);
               chk("R3 phy", hdr[9:5], e.phy);
               chk("R3 reg", hdr[4:0], e.rg);
               chk("R3 data", is_wr ? dsh : rdval, e.d);
               chk("R5 preamble", ones, e.pre);
             end else if (scan_on) begin
               chk("R8 scan op", is_wr, 0);
               chk("R8 scan phy", hdr[9:5], scan_phy);
               chk("R8 scan reg", hdr[4:0], scan_reg);
             end else begin
               chk("R7 unexpected frame", 1, 0);
             end
             st = 0; ones = 0; n = 0;
           end
         end
    endcase
  end

  always @(negedge mdc) begin
    if (st == 3 && hdr[11:10] == 2'b10) begin
      int u;
      u = n + 1;
      if (u == 1) mdio_in = 1'b1;
      else if (u == 2) mdio_in = 1'b0;
      else mdio_in = rdval[18-u];
    end else mdio_in = 1'b1;
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd5, s);
      if (!s[1]) return;
    end
  endtask

  task automatic push(input logic w, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    exp_t e;
    e.wr = w; e.phy = p; e.rg = r; e.d = d; e.pre = 6'(exp_pre);
    q.push_back(e);
  endtask

  task automatic do_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    push(1, p, r, d);
    wr(3'd2, {3'd0, r, 3'd0, p}); wr(3'd3, d); wr(3'd1, 16'h4);
    wait_idle(); wr(3'd1, 16'h0);
  endtask

  task automatic do_read(input logic [4:0] p, input logic [4:0] r, input string tag);
    logic [15:0] v;
    push(0, p, r, phy_mem[r]);
    wr(3'd2, {3'd0, r, 3'd0, p}); wr(3'd1, 16'h2);
    wait_idle();
    rd(3'd4, v); chk(tag, v, phy_mem[r]);
    wr(3'd1, 16'h0);
  endtask

  task automatic measure(input int d, input string tag);
    int t0, t1, t2;
    @(posedge mdc); t0 = cyc;
    @(negedge mdc); t1 = cyc;
    @(posedge mdc); t2 = cyc;
    chk({tag, " high"}, t1 - t0, d / 2);
    chk({tag, " period"}, t2 - t0, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int f0;
    for (int i = 0; i < 32; i++) phy_mem[i] = 16'(i * 16'h0101 + 16'h1234);
    repeat (3) @(negedge clk); rst_n = 1;

    // R1 reset state
    rd(3'd5, v); chk("R1 status", v, 0);
    rd(3'd4, v); chk("R1 rxdata", v, 0);
    rd(3'd0, v); chk("R1 mode", v, 0);
    chk("R1 mdc", mdc, 0);
    chk("R1 oe", mdio_oe, 0);

    // R2 divider 0 acts as 2
    push(1, 5'd1, 5'd2, 16'hA5A5);
    wr(3'd2, {3'd0, 5'd2, 3'd0, 5'd1}); wr(3'd3, 16'hA5A5); wr(3'd1, 16'h4);
    measure(2, "R2 div0");
    wait_idle(); wr(3'd1, 0);

    // R2 odd value forced even
    wr(3'd0, 16'h0007); rd(3'd0, v); chk("R2 bit0 zero", v, 16'h0006);
    push(1, 5'd1, 5'd3, 16'h0F0F);
    wr(3'd2, {3'd0, 5'd3, 3'd0, 5'd1}); wr(3'd3, 16'h0F0F); wr(3'd1, 16'h4);
    measure(6, "R2 div6");
    wait_idle(); wr(3'd1, 0);

    wr(3'd0, 16'h0008);
    // R3 write frames with several patterns
    do_write(5'd31, 5'd0, 16'hFFFF);
    do_write(5'd0, 5'd31, 16'h0000);
    do_write(5'd10, 5'd21, 16'h8001);
    // R4 reads
    do_read(5'd10, 5'd21, "R4 rxdata 8001");
    do_read(5'd7, 5'd9, "R4 rxdata model");

    // R6 busy timing
    push(1, 5'd4, 5'd4, 16'h1357);
    wr(3'd2, {3'd0, 5'd4, 3'd0, 5'd4}); wr(3'd3, 16'h1357); wr(3'd1, 16'h4);
    rd(3'd5, v); chk("R6 busy after command", v[1], 1);
    // R7 command and tx data during busy are ignored
    f0 = frames;
    wr(3'd3, 16'hDEAD); wr(3'd1, 16'h2);
    wait_idle();
    chk("R7 one frame", frames - f0, 1);
    chk("R7 latched data", phy_mem[4], 16'h1357);
    rd(3'd5, v); chk("R6 busy clear", v[1], 0);
    wr(3'd1, 0);
    repeat (50) @(negedge clk);
    chk("R7 no late frame", frames - f0, 1);

    // R9 write wins over read
    push(1, 5'd2, 5'd6, 16'h2468);
    wr(3'd2, {3'd0, 5'd6, 3'd0, 5'd2}); wr(3'd3, 16'h2468); wr(3'd1, 16'h6);
    wait_idle(); wr(3'd1, 0);
    chk("R9 write performed", phy_mem[6], 16'h2468);

    // R5 no preamble
    wr(3'd0, 16'h0108); exp_pre = 0;
    do_write(5'd5, 5'd11, 16'h3C3C);
    do_read(5'd5, 5'd11, "R5 read no preamble");
    wr(3'd0, 16'h0008); exp_pre = 32;

    // R8 scan
    phy_mem[1] = 16'h0000;
    scan_phy = 5'd3; scan_reg = 5'd1; scan_on = 1;
    wr(3'd2, {3'd0, 5'd1, 3'd0, 5'd3});
    f0 = frames;
    wr(3'd1, 16'h1);
    rd(3'd5, v); chk("R8 invalid at start", v[2], 1); chk("R8 busy", v[1], 1);
    wait (frames >= f0 + 1); repeat (20) @(negedge clk);
    rd(3'd5, v); chk("R8 invalid cleared", v[2], 0); chk("R8 link fail set", v[0], 1);
    phy_mem[1] = 16'h0004;
    f0 = frames;
    wait (frames >= f0 + 2); repeat (20) @(negedge clk);
    rd(3'd5, v); chk("R8 link fail cleared", v[0], 0);
    wr(3'd1, 16'h0);
    wait_idle();
    scan_on = 0;
    rd(3'd4, v); chk("R8 scan rxdata", v, 16'h0004);
    f0 = frames;
    repeat (300) @(negedge clk);
    chk("R8 scan stopped", frames - f0, 0);
    chk("R3 queue drained", q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule